// File: doc/BRIEF.md
# Processor Presence Bitmap with Hotplug Event Interrupt

This block records which processors are installed. It keeps one presence bit for each processor slot, and host software reads that map one byte at a time through a small I/O window. A sideband request port reports processors being added or removed. Each accepted request sets or clears the matching presence bit. It also latches a hotplug event flag, which software later clears by writing 1 to it.

The hotplug event flag is gated by its enable bit. The result is ORed with a masked power-management status term to give one level-sensitive system control interrupt (SCI). Firmware sees the interrupt, rescans the presence window and acknowledges the event. The set of processors present at power-up is a parameter vector that is loaded at reset. Requests that name a processor beyond the map are dropped and reported on an error output.

Top module: `cpuhp_presence_ctrl`

## Requirements
- R1: During reset the presence map loads `INIT_PRESENT` (default: processors 0 to 3 present), and the event flag, the event enable byte and `hp_err` become 0.
- R2: While `io_addr` is in `IO_BASE` .. `IO_BASE+31` (default 0xAF00 to 0xAF1F), `io_rdata` combinationally shows map byte N = `io_addr - IO_BASE`. Bit j of that byte is processor 8N+j.
- R3: An accepted request with `hp_plug`=1 sets the bit of processor `hp_id` from the next cycle on, and leaves all other bits unchanged.
- R4: An accepted request with `hp_plug`=0 clears the bit of processor `hp_id` from the next cycle on, and leaves all other bits unchanged.
- R5: Every accepted request sets the event flag from the next cycle on, whether it plugs or unplugs a processor and whether or not the bit changes. The flag is bit 2 (value 0x04) of the event status byte, which is read at `EVT_STS_ADDR` (default 0x0630). The other bits of that byte read as 0.
- R6: A request with `hp_id` >= `NUM_CPUS` (256) changes neither the map nor the event flag. `hp_err` is high for exactly the cycle after it.
- R7: Writes inside the presence window change nothing.
- R8: A write to `EVT_STS_ADDR` with data bit 2 set clears the event flag. The other data bits are ignored. The event enable byte at `EVT_EN_ADDR` (default 0x0631) is read/write and resets to 0.
- R9: If an accepted request and a write that clears the flag arrive in the same cycle, the flag ends up set.
- R10: `sci` is combinational. It is high when the event flag and enable bit 2 are both 1, or when `pm1_sts & pm1_en & 0x0521` is nonzero. The mask bits are timer 0, global lock 5, power button 8 and RTC 10.
- R11: Reads at any other address return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | Host I/O byte address |
| io_wr | input | 1 | Host single-byte write strobe |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Read data for `io_addr` (combinational) |
| hp_valid | input | 1 | Hotplug request valid, one cycle |
| hp_plug | input | 1 | 1 = processor added, 0 = removed |
| hp_id | input | 9 | Processor index |
| hp_err | output | 1 | Pulse: the previous request was out of range |
| pm1_sts | input | 16 | Power-management event status |
| pm1_en | input | 16 | Power-management event enable |
| sci | output | 1 | Level system control interrupt |

## Verification
The bench targets the first and last processors (byte 0 and byte 31, bit 7), so a design with wrong byte or bit arithmetic shows the wrong map bit. It sends unplug requests for processors that are already absent, which a design that sets the event only on a change of state would miss. It also sends IDs of 256 and above, which a design that truncates the ID would fold onto processor 0 or 44. It drives a clearing write in the same cycle as a request, which a design that gives the clear priority would lose. Writes that clear only the flag's neighbouring bits, presence-window writes and unmasked PM1 bits all target the same weakness: a design that decodes too loosely would corrupt state or raise a spurious interrupt.

// File: rtl/cpuhp_pkg.sv
package cpuhp_pkg;

    // Event status bit raised by hotplug activity
    localparam int unsigned EVT_BIT = 2;

    // PM1 bits that may contribute to the interrupt
    localparam int unsigned PM1_TMR_BIT  = 0;
    localparam int unsigned PM1_GBL_BIT  = 5;
    localparam int unsigned PM1_PWRB_BIT = 8;
    localparam int unsigned PM1_RTC_BIT  = 10;

    localparam logic [15:0] PM1_SCI_MASK = 16'((1 << PM1_TMR_BIT) | (1 << PM1_GBL_BIT) |
                                               (1 << PM1_PWRB_BIT) | (1 << PM1_RTC_BIT));

    localparam logic [7:0] UNMAPPED_BYTE = 8'hFF;

    function automatic logic [7:0] evt_sts_byte(input logic flag);
        logic [7:0] b;
        b = 8'h00;
        b[EVT_BIT] = flag;
        return b;
    endfunction

endpackage

// File: rtl/cpuhp_req_check.sv
module cpuhp_req_check #(
    parameter int unsigned NUM_CPUS = 256,
    parameter int unsigned ID_W     = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hp_valid,
    input  logic [ID_W-1:0] hp_id,
    output logic            accept,
    output logic            err
);
    localparam logic [ID_W:0] ID_LIMIT = (ID_W+1)'(NUM_CPUS);

    typedef struct packed {
        logic err;
    } chk_state_t;

    chk_state_t st_d, st_q;
    logic in_range;

    always_comb begin
        in_range = ({1'b0, hp_id} < ID_LIMIT);
        accept   = hp_valid && in_range;
        st_d     = st_q;
        st_d.err = hp_valid && !in_range;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err = st_q.err;

endmodule

// File: rtl/cpuhp_presence_map.sv
module cpuhp_presence_map #(
    parameter int unsigned        NUM_CPUS     = 256,
    parameter int unsigned        ID_W         = 9,
    parameter logic [NUM_CPUS-1:0] INIT_PRESENT = NUM_CPUS'(4'hF),
    localparam int unsigned       MAP_BYTES    = NUM_CPUS / 8,
    localparam int unsigned       OFF_W        = (MAP_BYTES > 1) ? $clog2(MAP_BYTES) : 1,
    localparam int unsigned       IDX_W        = $clog2(NUM_CPUS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_en,
    input  logic             upd_plug,
    input  logic [ID_W-1:0]  upd_id,
    input  logic [OFF_W-1:0] rd_off,
    output logic [7:0]       rd_byte
);
    typedef struct packed {
        logic [NUM_CPUS-1:0] bits;
    } map_state_t;

    map_state_t st_d, st_q;
    logic [MAP_BYTES-1:0][7:0] bytes;

    always_comb begin
        st_d = st_q;
        if (upd_en) begin
            st_d.bits[IDX_W'(upd_id)] = upd_plug;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.bits <= INIT_PRESENT;
        end else begin
            st_q <= st_d;
        end
    end

    // Byte view of the map, one slice per window offset
    for (genvar g = 0; g < MAP_BYTES; g++) begin : g_byte
        assign bytes[g] = st_q.bits[g*8 +: 8];
    end

    assign rd_byte = bytes[rd_off];

endmodule

// File: rtl/cpuhp_event_regs.sv
module cpuhp_event_regs
    import cpuhp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       evt_set,
    input  logic       sts_wr,
    input  logic       en_wr,
    input  logic [7:0] wdata,
    output logic       evt_flag,
    output logic [7:0] evt_en
);
    typedef struct packed {
        logic       flag;
        logic [7:0] en;
    } evt_state_t;

    evt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sts_wr && wdata[EVT_BIT]) begin
            st_d.flag = 1'b0;
        end
        // a new event overrides a simultaneous acknowledge
        if (evt_set) begin
            st_d.flag = 1'b1;
        end
        if (en_wr) begin
            st_d.en = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign evt_flag = st_q.flag;
    assign evt_en   = st_q.en;

endmodule

// File: rtl/cpuhp_sci_gen.sv
module cpuhp_sci_gen
    import cpuhp_pkg::*;
(
    input  logic        [15:0] pm1_sts,
    input  logic        [15:0] pm1_en,
    input  logic               evt_flag,
    input  logic               evt_en_bit,
    output logic               sci
);
    logic pm_term;
    logic gpe_term;

    always_comb begin
        pm_term  = |(pm1_sts & pm1_en & PM1_SCI_MASK);
        gpe_term = evt_flag & evt_en_bit;
        sci      = pm_term | gpe_term;
    end

endmodule

// File: rtl/cpuhp_presence_ctrl.sv
module cpuhp_presence_ctrl
    import cpuhp_pkg::*;
#(
    parameter int unsigned         NUM_CPUS     = 256,
    parameter int unsigned         ID_W         = 9,
    parameter int unsigned         ADDR_W       = 16,
    parameter logic [ADDR_W-1:0]   IO_BASE      = 16'hAF00,
    parameter logic [ADDR_W-1:0]   EVT_STS_ADDR = 16'h0630,
    parameter logic [ADDR_W-1:0]   EVT_EN_ADDR  = 16'h0631,
    parameter logic [NUM_CPUS-1:0] INIT_PRESENT = NUM_CPUS'(4'hF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic              hp_valid,
    input  logic              hp_plug,
    input  logic [ID_W-1:0]   hp_id,
    output logic              hp_err,
    input  logic [15:0]       pm1_sts,
    input  logic [15:0]       pm1_en,
    output logic              sci
);
    localparam int unsigned   MAP_BYTES = NUM_CPUS / 8;
    localparam int unsigned   OFF_W     = (MAP_BYTES > 1) ? $clog2(MAP_BYTES) : 1;
    localparam logic [ADDR_W:0] WIN_END = {1'b0, IO_BASE} + (ADDR_W+1)'(MAP_BYTES);

    logic             req_accept;
    logic             in_window;
    logic             hit_sts;
    logic             hit_en;
    logic [OFF_W-1:0] win_off;
    logic [7:0]       map_byte;
    logic             evt_flag;
    logic [7:0]       evt_en;

    always_comb begin
        in_window = ({1'b0, io_addr} >= {1'b0, IO_BASE}) && ({1'b0, io_addr} < WIN_END);
        hit_sts   = (io_addr == EVT_STS_ADDR);
        hit_en    = (io_addr == EVT_EN_ADDR);
        win_off   = OFF_W'(io_addr - IO_BASE);
    end

    cpuhp_req_check #(
        .NUM_CPUS (NUM_CPUS),
        .ID_W     (ID_W)
    ) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .hp_valid (hp_valid),
        .hp_id    (hp_id),
        .accept   (req_accept),
        .err      (hp_err)
    );

    cpuhp_presence_map #(
        .NUM_CPUS     (NUM_CPUS),
        .ID_W         (ID_W),
        .INIT_PRESENT (INIT_PRESENT)
    ) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_en   (req_accept),
        .upd_plug (hp_plug),
        .upd_id   (hp_id),
        .rd_off   (win_off),
        .rd_byte  (map_byte)
    );

    cpuhp_event_regs u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_set  (req_accept),
        .sts_wr   (io_wr && hit_sts),
        .en_wr    (io_wr && hit_en),
        .wdata    (io_wdata),
        .evt_flag (evt_flag),
        .evt_en   (evt_en)
    );

    cpuhp_sci_gen u_sci (
        .pm1_sts    (pm1_sts),
        .pm1_en     (pm1_en),
        .evt_flag   (evt_flag),
        .evt_en_bit (evt_en[EVT_BIT]),
        .sci        (sci)
    );

    // Read mux; writes into the window are not routed anywhere
    always_comb begin
        if (in_window) begin
            io_rdata = map_byte;
        end else if (hit_sts) begin
            io_rdata = evt_sts_byte(evt_flag);
        end else if (hit_en) begin
            io_rdata = evt_en;
        end else begin
            io_rdata = UNMAPPED_BYTE;
        end
    end

endmodule

// File: rtl/cpuhp_presence_ctrl_chk.sv
module cpuhp_presence_ctrl_chk
    import cpuhp_pkg::*;
#(
    parameter int unsigned       NUM_CPUS     = 256,
    parameter int unsigned       ID_W         = 9,
    parameter int unsigned       ADDR_W       = 16,
    parameter logic [ADDR_W-1:0] EVT_STS_ADDR = 16'h0630
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_wr,
    input logic [7:0]        io_wdata,
    input logic              hp_valid,
    input logic [ID_W-1:0]   hp_id,
    input logic              hp_err,
    input logic [15:0]       pm1_sts,
    input logic [15:0]       pm1_en,
    input logic              evt_flag,
    input logic [7:0]        evt_en,
    input logic              sci
);
    localparam logic [ID_W:0] ID_LIMIT = (ID_W+1)'(NUM_CPUS);

    logic good_req;
    logic bad_req;
    logic ack_wr;

    assign good_req = hp_valid && ({1'b0, hp_id} <  ID_LIMIT);
    assign bad_req  = hp_valid && ({1'b0, hp_id} >= ID_LIMIT);
    assign ack_wr   = io_wr && (io_addr == EVT_STS_ADDR) && io_wdata[EVT_BIT];

    a_r5_request_raises_flag: assert property (@(posedge clk) disable iff (!rst_n)
        good_req |=> evt_flag);

    a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (good_req && ack_wr) |=> evt_flag);

    a_r8_ack_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && !good_req) |=> !evt_flag);

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_flag && !ack_wr) |=> evt_flag);

    a_r6_bad_id_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        bad_req |=> hp_err);

    a_r6_err_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        hp_err |-> $past(bad_req));

    a_r6_bad_id_no_event: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_req && !evt_flag) |=> !evt_flag);

    a_r10_event_drives_sci: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_flag && evt_en[EVT_BIT]) |-> sci);

    a_r10_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_en[EVT_BIT] && ((pm1_sts & pm1_en & PM1_SCI_MASK) == 16'h0)) |-> !sci);

endmodule

bind cpuhp_presence_ctrl cpuhp_presence_ctrl_chk #(
    .NUM_CPUS     (NUM_CPUS),
    .ID_W         (ID_W),
    .ADDR_W       (ADDR_W),
    .EVT_STS_ADDR (EVT_STS_ADDR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_addr  (io_addr),
    .io_wr    (io_wr),
    .io_wdata (io_wdata),
    .hp_valid (hp_valid),
    .hp_id    (hp_id),
    .hp_err   (hp_err),
    .pm1_sts  (pm1_sts),
    .pm1_en   (pm1_en),
    .evt_flag (evt_flag),
    .evt_en   (evt_en),
    .sci      (sci)
);

// File: tb/cpuhp_presence_ctrl_bench.sv
`timescale 1ns/1ps
module cpuhp_presence_ctrl_bench;

    localparam int NCPU   = 256;
    localparam int IDW    = 9;
    localparam logic [15:0] BASE = 16'hAF00;
    localparam logic [15:0] STS  = 16'h0630;
    localparam logic [15:0] ENA  = 16'h0631;
    localparam logic [NCPU-1:0] INIT = NCPU'(4'hF);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = 16'h0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = 8'h0;
    logic [7:0]  io_rdata;
    logic        hp_valid = 1'b0;
    logic        hp_plug = 1'b0;
    logic [IDW-1:0] hp_id = '0;
    logic        hp_err;
    logic [15:0] pm1_sts = 16'h0;
    logic [15:0] pm1_en = 16'h0;
    logic        sci;

    always #2 clk = ~clk;

    cpuhp_presence_ctrl #(
        .INIT_PRESENT (INIT)
    ) u_cpuhp_presence_ctrl (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .hp_valid(hp_valid),
        .hp_plug(hp_plug), .hp_id(hp_id), .hp_err(hp_err),
        .pm1_sts(pm1_sts), .pm1_en(pm1_en), .sci(sci)
    );

    // Behavioural reference state
    bit [NCPU-1:0] m_map;
    bit            m_flag;
    bit [7:0]      m_en;
    bit            m_err;
    int checks = 0;
    int errors = 0;
    string tag_now = "R1";

    function automatic bit [7:0] ref_read(input logic [15:0] a);
        int off;
        off = int'(a) - int'(BASE);
        if (off >= 0 && off < NCPU/8) return m_map[off*8 +: 8];
        if (a == STS) return m_flag ? 8'h04 : 8'h00;
        if (a == ENA) return m_en;
        return 8'hFF;
    endfunction

    function automatic bit ref_sci();
        bit pm;
        pm = ((pm1_sts & pm1_en & 16'h0521) != 16'h0);
        return pm || (m_flag && m_en[2]);
    endfunction

    task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
        end
    endtask

    // compare combinational and registered outputs, then advance one clock
    task automatic cyc();
        bit acc;
        #1;
        check(tag_now, "io_rdata", io_rdata, ref_read(io_addr));
        check(tag_now, "sci", {7'b0, sci}, {7'b0, ref_sci()});
        check(tag_now, "hp_err", {7'b0, hp_err}, {7'b0, m_err});
        @(posedge clk);
        if (rst_n) begin
            acc = hp_valid && (int'(hp_id) < NCPU);
            m_err = hp_valid && !acc;
            if (acc) m_map[hp_id] = hp_plug;
            if (io_wr && io_addr == STS && io_wdata[2]) m_flag = 1'b0;
            if (acc) m_flag = 1'b1;
            if (io_wr && io_addr == ENA) m_en = io_wdata;
        end
        @(negedge clk);
    endtask

    task automatic quiet();
        hp_valid = 1'b0;
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input string tag);
        quiet();
        tag_now = tag;
        io_addr = a;
        cyc();
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
        quiet();
        tag_now = tag;
        io_addr = a;
        io_wdata = d;
        io_wr = 1'b1;
        cyc();
        io_wr = 1'b0;
    endtask

    task automatic req(input int id, input bit plug, input string tag);
        quiet();
        tag_now = tag;
        hp_valid = 1'b1;
        hp_plug = plug;
        hp_id = IDW'(id);
        cyc();
        hp_valid = 1'b0;
    endtask

    initial begin
        m_map = INIT;
        m_flag = 1'b0;
        m_en = 8'h00;
        m_err = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset contents
        rd(BASE, "R1");
        rd(BASE + 16'd31, "R1");
        rd(STS, "R1");
        rd(ENA, "R1");

        // R2 full window scan
        for (int i = 0; i < 32; i++) rd(BASE + 16'(i), "R2");

        // R11 unmapped addresses
        rd(16'hAEFF, "R11");
        rd(16'hAF20, "R11");
        rd(16'h0000, "R11");
        rd(16'hFFFF, "R11");

        // R3 plug, including the last processor; R5 flag follows
        req(9, 1'b1, "R3");
        rd(BASE + 16'd1, "R3");
        req(255, 1'b1, "R3");
        rd(BASE + 16'd31, "R3");
        rd(STS, "R5");

        // R8 only bit 2 acknowledges
        wr(STS, 8'hFB, "R8");
        rd(STS, "R8");
        wr(STS, 8'h04, "R8");
        rd(STS, "R8");
        wr(ENA, 8'hA5, "R8");
        rd(ENA, "R8");

        // R4 unplug; R5 flag even for an already-absent processor
        req(2, 1'b0, "R4");
        rd(BASE, "R4");
        rd(STS, "R5");
        wr(STS, 8'h04, "R5");
        req(2, 1'b0, "R5");
        rd(BASE, "R5");
        rd(STS, "R5");
        req(0, 1'b1, "R5");
        rd(STS, "R5");
        wr(STS, 8'hFF, "R8");

        // R6 out-of-range IDs
        req(256, 1'b1, "R6");
        rd(BASE, "R6");
        req(300, 1'b1, "R6");
        rd(BASE + 16'd5, "R6");
        req(511, 1'b0, "R6");
        rd(STS, "R6");
        rd(BASE + 16'd31, "R6");

        // R7 window writes ignored
        wr(BASE, 8'h00, "R7");
        rd(BASE, "R7");
        wr(BASE + 16'd5, 8'hFF, "R7");
        rd(BASE + 16'd5, "R7");

        // R10 interrupt from the event path
        wr(ENA, 8'h04, "R10");
        rd(STS, "R10");
        req(10, 1'b1, "R10");
        rd(STS, "R10");
        wr(ENA, 8'h00, "R10");
        rd(ENA, "R10");
        wr(ENA, 8'h04, "R10");
        rd(STS, "R10");
        wr(STS, 8'h04, "R10");
        rd(STS, "R10");

        // R10 interrupt from the PM1 path
        pm1_en = 16'h0521;
        pm1_sts = 16'h0001; rd(16'h1234, "R10");
        pm1_sts = 16'h0020; rd(16'h1234, "R10");
        pm1_sts = 16'h0100; rd(16'h1234, "R10");
        pm1_sts = 16'h0400; rd(16'h1234, "R10");
        pm1_en = 16'hFFFF;
        pm1_sts = 16'h0002; rd(16'h1234, "R10");
        pm1_en = 16'h0000;
        pm1_sts = 16'hFFFF; rd(16'h1234, "R10");
        pm1_sts = 16'h0000;

        // R9 request and acknowledge in one cycle
        quiet();
        tag_now = "R9";
        io_addr = STS;
        io_wdata = 8'h04;
        io_wr = 1'b1;
        hp_valid = 1'b1;
        hp_plug = 1'b1;
        hp_id = IDW'(11);
        cyc();
        rd(STS, "R9");
        rd(BASE + 16'd1, "R9");
        wr(STS, 8'h04, "R9");
        rd(STS, "R9");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule